// File: doc/BRIEF.md
# Packed SIMD Integer ALU

This block is a 64-bit integer execution unit with its own file of eight 64-bit data registers. Each operation names two source registers, a destination register and an element size. The unit treats each operand as a row of independent lanes: eight 8-bit lanes, four 16-bit lanes, two 32-bit lanes, or one 64-bit quantity. Every lane is computed in the same cycle, and the result is written back to the destination register.

Add, subtract, their saturating forms and compare-equal work only inside lanes. No carry or borrow crosses a lane boundary, and none of these operations exists for the 64-bit size. Bitwise logic acts on all 64 bits whatever size is given. Shifts work at any of the four sizes, including a whole-word shift. A load-immediate operation is the only way data enters the register file. The written value, together with its register index, appears on the write-back port one cycle after the operation is issued.

Top module: `psimd_alu`

## Requirements
- R1: After reset every register holds zero and `wb_valid` is low with `wb_data` zero.
- R2: An operation accepted at a clock edge writes its destination register at that edge. It also drives `wb_valid`=1, `wb_idx`=`dst` and `wb_data`=the result until the next edge. The written value is visible to an operation issued in the following cycle. Opcode 0 (load) writes `imm` unchanged.
- R3: Opcodes 1 (add) and 2 (subtract, a minus b) wrap within each lane. No carry or borrow passes between lanes. `elem_sz` encodes 0=8-bit, 1=16-bit, 2=32-bit and 3=64-bit lanes, and lane 0 sits in the least significant bits.
- R4: Opcodes 3 (signed saturating add) and 5 (signed saturating subtract) clamp each lane to its most positive or most negative two's-complement value on overflow.
- R5: Opcodes 4 (unsigned saturating add) and 6 (unsigned saturating subtract) clamp each lane to all ones on carry out and to zero on borrow.
- R6: Opcode 7 (compare-equal) writes all ones into each lane whose two operands are equal and zero into every other lane.
- R7: Opcodes 8 (and), 9 (or), 10 (xor) and 11 (not-a and b) act on all 64 bits whatever `elem_sz` holds.
- R8: Opcodes 12 (shift left) and 13 (logical shift right) shift every lane by the whole 64-bit value of source register b. A count equal to or above the lane width gives zero.
- R9: Opcode 14 (arithmetic shift right) shifts in copies of each lane's sign bit. A count equal to or above the lane width fills the lane with its sign.
- R10: Opcodes 1 to 7 with `elem_sz`=3 write nothing. `wb_valid` stays low and the destination register keeps its value.
- R11: Opcode 15, or any operation with `op_valid` low, writes nothing and leaves every register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_code | input | 4 | Operation select |
| elem_sz | input | 2 | Lane size: 0=8, 1=16, 2=32, 3=64 bits |
| src_a | input | 3 | Index of operand register a |
| src_b | input | 3 | Index of operand register b (also the shift count) |
| dst | input | 3 | Index of destination register |
| imm | input | 64 | Value written by the load opcode |
| wb_valid | output | 1 | A register was written at the last edge |
| wb_idx | output | 3 | Index of the register written |
| wb_data | output | 64 | Value written |

## Verification
The hardest case to bring about from the ports is a single word in which some lanes clamp high, some clamp low and some pass through unsaturated. The load opcode places hand-picked words with lanes at the edge of their range, such as 0x7F next to 0x80. Each saturating opcode is then applied at all three lane sizes to those same registers, so the same bits are cut at different lane boundaries. Shift counts of 64 and 1000 are also used. Their low-order bits look like small legal counts, so a design that reads only the low bits would return a wrong, non-zero lane.

// File: rtl/psimd_pkg.sv
package psimd_pkg;

  typedef enum logic [3:0] {
    OP_LDI   = 4'd0,
    OP_ADD   = 4'd1,
    OP_SUB   = 4'd2,
    OP_ADDS  = 4'd3,
    OP_ADDUS = 4'd4,
    OP_SUBS  = 4'd5,
    OP_SUBUS = 4'd6,
    OP_CMPEQ = 4'd7,
    OP_AND   = 4'd8,
    OP_OR    = 4'd9,
    OP_XOR   = 4'd10,
    OP_ANDN  = 4'd11,
    OP_SLL   = 4'd12,
    OP_SRL   = 4'd13,
    OP_SRA   = 4'd14,
    OP_RSV   = 4'd15
  } op_e;

  localparam int NSZ = 4;
  localparam logic [1:0] SZ_WORD = 2'd3;

  function automatic logic lane_only(op_e op);
    return (op >= OP_ADD) && (op <= OP_CMPEQ);
  endfunction

  function automatic logic is_bitwise(op_e op);
    return (op >= OP_AND) && (op <= OP_ANDN);
  endfunction

endpackage

// File: rtl/psimd_regfile.sv
module psimd_regfile #(
  parameter int NREG = 8,
  parameter int DW   = 64,
  localparam int IW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] rd_a_idx,
  input  logic [IW-1:0] rd_b_idx,
  output logic [DW-1:0] rd_a,
  output logic [DW-1:0] rd_b,
  input  logic          we,
  input  logic [IW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data
);

  logic [DW-1:0] mem [NREG];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) mem[i] <= '0;
    end else if (we) begin
      mem[wr_idx] <= wr_data;
    end
  end

  assign rd_a = mem[rd_a_idx];
  assign rd_b = mem[rd_b_idx];

  // R2
  rf_write_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && rd_a_idx == wr_idx) |=> (rd_a == $past(wr_data) || $past(rd_a_idx) != rd_a_idx));

endmodule

// File: rtl/psimd_lanes.sv
module psimd_lanes
  import psimd_pkg::*;
#(
  parameter int DW = 64,
  parameter int LW = 8,
  localparam int NL  = DW / LW,
  localparam int SHW = $clog2(LW)
) (
  input  op_e           op_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  output logic [DW-1:0] res_o
);

  localparam logic [LW-1:0] SMAX = {1'b0, {(LW-1){1'b1}}};
  localparam logic [LW-1:0] SMIN = {1'b1, {(LW-1){1'b0}}};

  logic shift_oversize;
  assign shift_oversize = (b_i >= DW'(LW));

  function automatic logic [LW-1:0] lane_op(op_e op, logic [LW-1:0] a, logic [LW-1:0] b,
                                            logic [SHW-1:0] sh, logic big);
    logic [LW:0] sum;
    logic [LW:0] diff;
    logic        s_ovf_add;
    logic        s_ovf_sub;
    sum       = {1'b0, a} + {1'b0, b};
    diff      = {1'b0, a} - {1'b0, b};
    s_ovf_add = (a[LW-1] == b[LW-1]) && (sum[LW-1] != a[LW-1]);
    s_ovf_sub = (a[LW-1] != b[LW-1]) && (diff[LW-1] != a[LW-1]);
    case (op)
      OP_ADD:   return sum[LW-1:0];
      OP_SUB:   return diff[LW-1:0];
      OP_ADDS:  return s_ovf_add ? (a[LW-1] ? SMIN : SMAX) : sum[LW-1:0];
      OP_SUBS:  return s_ovf_sub ? (a[LW-1] ? SMIN : SMAX) : diff[LW-1:0];
      OP_ADDUS: return sum[LW] ? {LW{1'b1}} : sum[LW-1:0];
      OP_SUBUS: return diff[LW] ? '0 : diff[LW-1:0];
      OP_CMPEQ: return (a == b) ? {LW{1'b1}} : '0;
      OP_SLL:   return big ? '0 : (a << sh);
      OP_SRL:   return big ? '0 : (a >> sh);
      OP_SRA:   return big ? {LW{a[LW-1]}} : $unsigned($signed(a) >>> sh);
      default:  return '0;
    endcase
  endfunction

  for (genvar l = 0; l < NL; l++) begin : g_lane
    assign res_o[l*LW +: LW] = lane_op(op_i, a_i[l*LW +: LW], b_i[l*LW +: LW],
                                       b_i[SHW-1:0], shift_oversize);
  end

endmodule

// File: rtl/psimd_alu.sv
module psimd_alu
  import psimd_pkg::*;
#(
  parameter int NREG = 8,
  parameter int DW   = 64,
  localparam int IW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  input  logic [3:0]    op_code,
  input  logic [1:0]    elem_sz,
  input  logic [IW-1:0] src_a,
  input  logic [IW-1:0] src_b,
  input  logic [IW-1:0] dst,
  input  logic [DW-1:0] imm,
  output logic          wb_valid,
  output logic [IW-1:0] wb_idx,
  output logic [DW-1:0] wb_data
);

  op_e           op;
  logic [DW-1:0] rd_a, rd_b;
  logic [DW-1:0] lane_res [NSZ];
  logic [DW-1:0] bitwise_res;
  logic [DW-1:0] result;
  logic          illegal_wide;
  logic          wr_fire;

  assign op           = op_e'(op_code);
  assign illegal_wide = lane_only(op) && (elem_sz == SZ_WORD);
  assign wr_fire      = op_valid && (op != OP_RSV) && !illegal_wide;

  psimd_regfile #(.NREG(NREG), .DW(DW)) u_rf (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_a_idx (src_a),
    .rd_b_idx (src_b),
    .rd_a     (rd_a),
    .rd_b     (rd_b),
    .we       (wr_fire),
    .wr_idx   (dst),
    .wr_data  (result)
  );

  for (genvar s = 0; s < NSZ; s++) begin : g_sz
    psimd_lanes #(.DW(DW), .LW(8 << s)) u_lanes (
      .op_i  (op),
      .a_i   (rd_a),
      .b_i   (rd_b),
      .res_o (lane_res[s])
    );
  end

  always_comb begin
    case (op)
      OP_AND:  bitwise_res = rd_a & rd_b;
      OP_OR:   bitwise_res = rd_a | rd_b;
      OP_XOR:  bitwise_res = rd_a ^ rd_b;
      default: bitwise_res = ~rd_a & rd_b;
    endcase
  end

  always_comb begin
    if (op == OP_LDI)        result = imm;
    else if (is_bitwise(op)) result = bitwise_res;
    else                     result = lane_res[elem_sz];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wb_valid <= 1'b0;
      wb_idx   <= '0;
      wb_data  <= '0;
    end else begin
      wb_valid <= wr_fire;
      if (wr_fire) begin
        wb_idx  <= dst;
        wb_data <= result;
      end
    end
  end

  // Lane-wise helpers for the checks below
  function automatic logic lanes_ge(logic [DW-1:0] x, logic [DW-1:0] y, logic [1:0] sz);
    logic ok;
    ok = 1'b1;
    case (sz)
      2'd0: for (int l = 0; l < DW/8; l++)  if (x[l*8 +: 8]   < y[l*8 +: 8])   ok = 1'b0;
      2'd1: for (int l = 0; l < DW/16; l++) if (x[l*16 +: 16] < y[l*16 +: 16]) ok = 1'b0;
      2'd2: for (int l = 0; l < DW/32; l++) if (x[l*32 +: 32] < y[l*32 +: 32]) ok = 1'b0;
      default: ok = (x >= y);
    endcase
    return ok;
  endfunction

  function automatic logic lanes_uniform(logic [DW-1:0] x, logic [1:0] sz);
    logic ok;
    ok = 1'b1;
    case (sz)
      2'd0: for (int l = 0; l < DW/8; l++)
              if (x[l*8 +: 8] != '0 && x[l*8 +: 8] != '1) ok = 1'b0;
      2'd1: for (int l = 0; l < DW/16; l++)
              if (x[l*16 +: 16] != '0 && x[l*16 +: 16] != '1) ok = 1'b0;
      2'd2: for (int l = 0; l < DW/32; l++)
              if (x[l*32 +: 32] != '0 && x[l*32 +: 32] != '1) ok = 1'b0;
      default: ok = (x == '0) || (x == '1);
    endcase
    return ok;
  endfunction

  // R2
  load_passes_imm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op == OP_LDI) |=> (wb_valid && wb_data == $past(imm)));

  // R5
  addus_no_decrease_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && op == OP_ADDUS) |=> lanes_ge(wb_data, $past(rd_a), $past(elem_sz)));

  // R5
  subus_no_increase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && op == OP_SUBUS) |=> lanes_ge($past(rd_a), wb_data, $past(elem_sz)));

  // R6
  cmpeq_uniform_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && op == OP_CMPEQ) |=> lanes_uniform(wb_data, $past(elem_sz)));

  // R7
  xor_self_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && op == OP_XOR && src_a == src_b) |=> (wb_data == '0));

  // R10
  wide_arith_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && lane_only(op) && elem_sz == SZ_WORD) |=> !wb_valid);

  // R11
  reserved_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_valid || op == OP_RSV) |=> !wb_valid);

endmodule

// File: tb/psimd_alu_tb.sv
module psimd_alu_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [3:0]  op_code = '0;
  logic [1:0]  elem_sz = '0;
  logic [2:0]  src_a = '0, src_b = '0, dst = '0;
  logic [63:0] imm = '0;
  logic        wb_valid;
  logic [2:0]  wb_idx;
  logic [63:0] wb_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [63:0] shadow [8];

  psimd_alu u_dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .elem_sz(elem_sz), .src_a(src_a), .src_b(src_b), .dst(dst), .imm(imm),
    .wb_valid(wb_valid), .wb_idx(wb_idx), .wb_data(wb_data)
  );

  always #2 clk = ~clk;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Reference: bit 64 = a write happens, bits 63:0 = written value
  function automatic logic [64:0] ref_op(input int op, input int sz, input logic [63:0] a,
                                         input logic [63:0] b, input logic [63:0] im);
    int lw, n;
    logic [63:0] m, ua, ub, r, lane;
    longint sa, sb, t, hi, lo;
    if (op == 15) return '0;
    if (op == 0) return {1'b1, im};
    if (op == 8)  return {1'b1, a & b};
    if (op == 9)  return {1'b1, a | b};
    if (op == 10) return {1'b1, a ^ b};
    if (op == 11) return {1'b1, ~a & b};
    if (op <= 7 && sz == 3) return '0;
    lw = 8 << sz;
    n  = 64 / lw;
    m  = (lw == 64) ? ~64'h0 : ((64'h1 << lw) - 64'h1);
    r  = '0;
    for (int i = 0; i < n; i++) begin
      ua = (a >> (i * lw)) & m;
      ub = (b >> (i * lw)) & m;
      sa = 0; sb = 0; hi = 0; lo = 0;
      if (lw < 64) begin
        sa = ua[lw-1] ? longint'(ua) - (longint'(1) << lw) : longint'(ua);
        sb = ub[lw-1] ? longint'(ub) - (longint'(1) << lw) : longint'(ub);
        hi = (longint'(1) << (lw - 1)) - 1;
        lo = -(longint'(1) << (lw - 1));
      end
      case (op)
        1: lane = (ua + ub) & m;
        2: lane = (ua - ub) & m;
        3: begin t = sa + sb; if (t > hi) t = hi; if (t < lo) t = lo; lane = 64'(t) & m; end
        5: begin t = sa - sb; if (t > hi) t = hi; if (t < lo) t = lo; lane = 64'(t) & m; end
        4: lane = (ua + ub > m) ? m : ua + ub;
        6: lane = (ua < ub) ? 64'h0 : ua - ub;
        7: lane = (ua == ub) ? m : 64'h0;
        12: lane = (b >= 64'(lw)) ? 64'h0 : (ua << b) & m;
        13: lane = (b >= 64'(lw)) ? 64'h0 : (ua >> b);
        default: begin
          if (b >= 64'(lw)) lane = ua[lw-1] ? m : 64'h0;
          else lane = (ua >> b) | (ua[lw-1] ? (m & ~(m >> b)) : 64'h0);
        end
      endcase
      r = r | (lane << (i * lw));
    end
    return {1'b1, r};
  endfunction

  task automatic run_op(input string tag, input bit vld, input int op, input int sz,
                        input int a, input int b, input int d, input logic [63:0] im);
    logic [64:0] e;
    e = vld ? ref_op(op, sz, shadow[a], shadow[b], im) : '0;
    @(negedge clk);
    op_valid = vld; op_code = 4'(op); elem_sz = 2'(sz);
    src_a = 3'(a); src_b = 3'(b); dst = 3'(d); imm = im;
    @(negedge clk);
    op_valid = 1'b0;
    chk({tag, " valid"}, {63'h0, wb_valid}, {63'h0, e[64]});
    if (e[64]) begin
      chk({tag, " data"}, wb_data, e[63:0]);
      chk({tag, " idx"}, {61'h0, wb_idx}, 64'(d));
      shadow[d] = e[63:0];
    end
  endtask

  task automatic load(input int d, input logic [63:0] v);
    run_op("R2 load", 1, 0, 0, 0, 0, d, v);
  endtask

  task automatic readback(input string tag, input int r);
    run_op(tag, 1, 9, 0, r, r, r, 64'h0);
  endtask

  task automatic t_reset;
    chk("R1 reset wb_valid", {63'h0, wb_valid}, 64'h0);
    chk("R1 reset wb_data", wb_data, 64'h0);
    for (int r = 0; r < 8; r++) readback("R1 regs zero", r);
  endtask

  task automatic t_load;
    load(1, 64'hDEAD_BEEF_0123_4567);
    chk("R2 literal", wb_data, 64'hDEAD_BEEF_0123_4567);
    run_op("R2 back-to-back", 1, 1, 0, 1, 1, 2, 64'h0);
  endtask

  task automatic t_wrap;
    load(1, 64'hFFFF_FFFF_FFFF_FFFF);
    load(2, 64'h0101_0101_0101_0101);
    run_op("R3 add8 carry", 1, 1, 0, 1, 2, 3, 64'h0);
    chk("R3 add8 literal", wb_data, 64'h0000_0000_0000_0000);
    load(1, 64'hFF80_7FFF_0001_FFFF);
    load(2, 64'h0180_0001_FFFF_0001);
    for (int s = 0; s < 3; s++) begin
      run_op("R3 add", 1, 1, s, 1, 2, 3, 64'h0);
      run_op("R3 sub", 1, 2, s, 1, 2, 4, 64'h0);
      run_op("R3 sub rev", 1, 2, s, 2, 1, 4, 64'h0);
    end
  endtask

  task automatic t_sat_s;
    load(1, 64'h7F7F_7F7F_7F7F_7F7F);
    load(2, 64'h0101_0101_0101_0101);
    run_op("R4 adds8 clamp", 1, 3, 0, 1, 2, 3, 64'h0);
    chk("R4 adds8 literal", wb_data, 64'h7F7F_7F7F_7F7F_7F7F);
    load(1, 64'h7F80_0105_7FFF_8000);
    load(2, 64'h0180_7FFF_0001_8000);
    for (int s = 0; s < 3; s++) begin
      run_op("R4 adds", 1, 3, s, 1, 2, 3, 64'h0);
      run_op("R4 subs", 1, 5, s, 1, 2, 3, 64'h0);
      run_op("R4 subs rev", 1, 5, s, 2, 1, 3, 64'h0);
    end
  endtask

  task automatic t_sat_u;
    load(1, 64'hF0F0_0010_FFFF_0005);
    load(2, 64'h2010_00F0_0001_0007);
    for (int s = 0; s < 3; s++) begin
      run_op("R5 addus", 1, 4, s, 1, 2, 3, 64'h0);
      run_op("R5 subus", 1, 6, s, 1, 2, 3, 64'h0);
    end
    run_op("R5 subus zero", 1, 6, 0, 2, 1, 3, 64'h0);
  endtask

  task automatic t_cmp;
    load(1, 64'h1234_5678_9ABC_DEF0);
    load(2, 64'h1234_0078_9ABC_DE00);
    for (int s = 0; s < 3; s++) run_op("R6 cmpeq", 1, 7, s, 1, 2, 3, 64'h0);
    run_op("R6 cmpeq self", 1, 7, 1, 1, 1, 3, 64'h0);
    chk("R6 self literal", wb_data, 64'hFFFF_FFFF_FFFF_FFFF);
  endtask

  task automatic t_logic;
    load(1, 64'hF0F0_AAAA_0000_FFFF);
    load(2, 64'h0FF0_5555_1234_F00F);
    for (int op = 8; op <= 11; op++) begin
      run_op("R7 logic sz0", 1, op, 0, 1, 2, 3, 64'h0);
      run_op("R7 logic sz3", 1, op, 3, 1, 2, 4, 64'h0);
    end
  endtask

  task automatic t_shift;
    logic [63:0] cnts [6];
    cnts = '{64'd3, 64'd8, 64'd16, 64'd40, 64'd64, 64'd1000};
    load(1, 64'h8123_4567_F9AB_CDEF);
    for (int c = 0; c < 6; c++) begin
      load(6, cnts[c]);
      for (int s = 0; s < 4; s++) begin
        run_op("R8 sll", 1, 12, s, 1, 6, 3, 64'h0);
        run_op("R8 srl", 1, 13, s, 1, 6, 3, 64'h0);
        run_op("R9 sra", 1, 14, s, 1, 6, 3, 64'h0);
      end
    end
    load(6, 64'd8);
    run_op("R9 sra8 fill", 1, 14, 0, 1, 6, 3, 64'h0);
    chk("R9 sra8 literal", wb_data, 64'hFF00_0000_FFFF_FFFF);
  endtask

  task automatic t_illegal;
    load(5, 64'hCAFE_F00D_1234_5678);
    for (int op = 1; op <= 7; op++) run_op("R10 wide arith", 1, op, 3, 1, 2, 5, 64'h0);
    readback("R10 dst kept", 5);
    chk("R10 literal", wb_data, 64'hCAFE_F00D_1234_5678);
  endtask

  task automatic t_ignored;
    load(7, 64'h0BAD_0BAD_0BAD_0BAD);
    run_op("R11 reserved", 1, 15, 0, 1, 2, 7, 64'h0);
    run_op("R11 not valid", 0, 0, 0, 1, 2, 7, 64'hFFFF_0000_FFFF_0000);
    readback("R11 dst kept", 7);
    chk("R11 literal", wb_data, 64'h0BAD_0BAD_0BAD_0BAD);
  endtask

  initial begin
    for (int r = 0; r < 8; r++) shadow[r] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_load();
    t_wrap();
    t_sat_s();
    t_sat_u();
    t_cmp();
    t_logic();
    t_shift();
    t_illegal();
    t_ignored();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule